// File: doc/BRIEF.md
# Page-Erase Row-Program Flash Array Model

This block is a synthesizable behavioural model of a small embedded flash array and the controller that sits in front of it. Software picks an operation through a three-bit control word (program mode, erase mode, high-voltage enable). It then latches a target with one array write and starts the operation by raising the high-voltage bit. Erase restores a whole aligned 64-byte page to all ones. Program can only clear bits, one byte at a time, inside the aligned 32-byte row that was latched. A protection boundary register refuses any operation whose page or row starts at or above the boundary. The analog settling times become a programmable busy period counted in clock cycles.

Reads use a combinational byte port. While the array is busy, every read returns 0xFF. Misuse raises a sticky error flag and leaves the array untouched: refused targets, stray program addresses, a high-voltage request with nothing armed, or a conflicting control word.

Top module: `flash_pe_model`

## Requirements
- R1: After reset every byte reads 0xFF, busy and err are low, and the protection boundary equals 2**ADDR_W, so nothing is protected.
- R2: Control word bits: bit0 selects program mode, bit1 selects erase mode, bit2 is the high-voltage enable. A control write with bit0 and bit1 both set is rejected, leaves the control state and any armed target unchanged, and sets err.
- R3: In program or erase mode with high voltage off and nothing armed, an array write arms the unit holding its address: the page for erase, the row for program. If that unit's base address is at or above the boundary, nothing is armed and err is set.
- R4: A control write that sets high voltage while armed and in the same mode makes busy high from the next cycle for max(hv_delay,1) cycles. Setting high voltage when not armed stores no high voltage, starts no busy period and sets err.
- R5: While busy is high, rd_data is 0xFF. Otherwise rd_data is the stored byte at rd_addr, with no clock delay.
- R6: An erase finishes on the last busy cycle. All bytes of the armed page then read 0xFF and every other byte is unchanged.
- R7: In program mode with high voltage on and not busy, an array write inside the armed row updates that byte to old AND data, visible the next cycle. A write outside the row is dropped and sets err.
- R8: Array writes are ignored with no mode selected, while busy, in erase mode once armed, and in the same cycle as an accepted control write.
- R9: err stays set until the next accepted control write that does not itself raise an error. Control writes while busy are ignored.
- R10: A control write that changes the mode bits disarms the latched target.
- R11: A protection write loads the boundary at any time; bytes below it remain erasable and programmable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Read byte (0xFF while busy) |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | ADDR_W | Array write address |
| wr_data | input | 8 | Array write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: bit2 high voltage, bit1 erase, bit0 program |
| hv_delay | input | DLY_W | Busy length in cycles, sampled when high voltage starts |
| prot_we | input | 1 | Protection boundary write strobe |
| prot_wdata | input | ADDR_W+1 | New protection boundary |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky error flag |

## Verification
rd_data is combinational, so the bench checks a byte in the same half cycle it sets rd_addr. A program write shows up one edge after it is driven. Busy rises on the edge that accepts the high-voltage write and lasts max(hv_delay,1) edges, and the erase result appears as busy falls. The bench drives each stimulus on a falling edge, steps from falling edge to falling edge while counting the expected busy span, and reads results only at falling edges. Full-array sweeps compare every byte against an arithmetic model after each group of operations.

// File: rtl/flash_pe_model.sv
`timescale 1ns/1ps
module flash_pe_model #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 64,
  parameter int ROW_BYTES  = 32,
  parameter int DLY_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic [DLY_W-1:0]  hv_delay,
  input  logic              prot_we,
  input  logic [ADDR_W:0]   prot_wdata,
  output logic              busy,
  output logic              err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int RW_W  = $clog2(ROW_BYTES);

  logic [7:0]        mem [DEPTH];
  logic              prog_q, erase_q, hv_q, armed_q, err_q;
  logic [ADDR_W-1:0] lat_q;
  logic [DLY_W-1:0]  cnt_q;
  logic [ADDR_W:0]   bound_q;

  assign busy    = cnt_q != '0;
  assign err     = err_q;
  assign rd_data = busy ? 8'hFF : mem[rd_addr];

  logic same_mode, ctl_ok, ctl_both, hv_bad, hv_start, wr_ok;
  logic prot_hit, do_latch, do_prog, in_row, erase_fire;
  logic [ADDR_W-1:0] unit_base;

  assign same_mode  = ctl_wdata[1:0] == {erase_q, prog_q};
  assign ctl_ok     = ctl_we && !busy;
  assign ctl_both   = &ctl_wdata[1:0];
  assign hv_bad     = ctl_wdata[2] && !(armed_q && same_mode);
  assign hv_start   = ctl_ok && !ctl_both && ctl_wdata[2] && !hv_bad && !hv_q;
  assign wr_ok      = wr_en && !busy && !ctl_ok;
  assign unit_base  = erase_q ? {wr_addr[ADDR_W-1:PG_W], {PG_W{1'b0}}}
                              : {wr_addr[ADDR_W-1:RW_W], {RW_W{1'b0}}};
  assign prot_hit   = {1'b0, unit_base} >= bound_q;
  assign do_latch   = wr_ok && (prog_q || erase_q) && !hv_q && !armed_q;
  assign do_prog    = wr_ok && prog_q && hv_q && armed_q;
  assign in_row     = wr_addr[ADDR_W-1:RW_W] == lat_q[ADDR_W-1:RW_W];
  assign erase_fire = erase_q && cnt_q == DLY_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      hv_q    <= 1'b0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
      lat_q   <= '0;
      cnt_q   <= '0;
      bound_q <= (ADDR_W+1)'(DEPTH);
    end else begin
      if (prot_we) bound_q <= prot_wdata;
      if (hv_start) cnt_q <= (hv_delay == '0) ? DLY_W'(1) : hv_delay;
      else if (busy) cnt_q <= cnt_q - 1'b1;
      if (ctl_ok) begin
        if (ctl_both) err_q <= 1'b1;
        else begin
          prog_q  <= ctl_wdata[0];
          erase_q <= ctl_wdata[1];
          hv_q    <= ctl_wdata[2] && !hv_bad;
          armed_q <= armed_q && same_mode;
          err_q   <= hv_bad;
        end
      end else if (do_latch) begin
        if (prot_hit) err_q <= 1'b1;
        else begin
          armed_q <= 1'b1;
          lat_q   <= wr_addr;
        end
      end else if (do_prog && !in_row) begin
        err_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (busy && erase_fire) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        mem[{lat_q[ADDR_W-1:PG_W], PG_W'(i)}] <= 8'hFF;
    end else if (do_prog && in_row) begin
      mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  logic [DLY_W-1:0] run_q, exp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      exp_q <= '0;
    end else if (hv_start) begin
      run_q <= '0;
      exp_q <= (hv_delay == '0) ? DLY_W'(1) : hv_delay;
    end else if (busy) begin
      run_q <= run_q + 1'b1;
    end
  end

  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hv_start |=> busy);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == exp_q);

  p_both_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !busy && ctl_both) |=> err && $stable({prog_q, erase_q, hv_q, armed_q}));

  p_prot_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_latch && prot_hit) |=> err && !armed_q);

  p_erase_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && erase_q && rd_addr[ADDR_W-1:PG_W] == lat_q[ADDR_W-1:PG_W])
      |-> rd_data == 8'hFF);

  p_prog_clear_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !ctl_we && prog_q && hv_q && armed_q && rd_addr == wr_addr)
      |=> (!$stable(rd_addr) || (rd_data & ~$past(rd_data)) == 8'h00));

  p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_we && !prog_q && !erase_q && !busy && rd_addr == wr_addr)
      |=> (!$stable(rd_addr) || $stable(rd_data)));
endmodule

// File: tb/test_flash_pe_model.sv
`timescale 1ns/1ps
module test_flash_pe_model;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] rd_data, wr_data = '0;
  logic wr_en = 1'b0, ctl_we = 1'b0, prot_we = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic [7:0] hv_delay = '0;
  logic [AW:0] prot_wdata = '0;
  logic busy, err;

  logic [7:0] model [DEPTH];
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_pe_model i_flash_pe_model (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .hv_delay(hv_delay),
    .prot_we(prot_we), .prot_wdata(prot_wdata), .busy(busy), .err(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [2:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string req);
    rd_addr = AW'(a); #1ps;
    chk(rd_data == model[a], req, rd_data, model[a]);
  endtask

  task automatic sweep(input string req);
    int miss = 0, first = -1;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a); #1ps;
      if (rd_data != model[a]) begin
        miss++;
        if (first < 0) first = a;
      end
    end
    chk(miss == 0, req, miss, 0);
    if (first >= 0) $display("  first mismatch at %0d", first);
  endtask

  task automatic hv_run(input logic [2:0] v, input int d, input string req);
    int e = (d == 0) ? 1 : d;
    bit ok = 1'b1;
    hv_delay = 8'(d);
    ctl(v);
    for (int k = 0; k < e; k++) begin
      #1ps;
      if (!busy || rd_data != 8'hFF) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok && !busy, req, {ok, busy}, 2);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !err, "R1 flags", {busy, err}, 0);
    sweep("R1 erased array");

    // R7 R4 R5 program every row, delays 0..3
    for (int r = 0; r < DEPTH / 32; r++) begin
      int base = r * 32;
      rd_addr = AW'(base);
      ctl(3'b001);
      wr(base + (r % 32), 8'h00);
      hv_run(3'b101, r % 4, "R4 R5 busy span");
      for (int b = 0; b < 32; b++) begin
        logic [7:0] v = 8'((base + b) * 37 + 11);
        wr(base + b, v);
        model[base + b] &= v;
      end
      if (r % 2 == 0)
        for (int b = 0; b < 32; b++) begin
          logic [7:0] v = 8'((base + b) * 7 + 3) | 8'h81;
          wr(base + b, v);
          model[base + b] &= v;
        end
      chk(!err, "R7 in-row no error", err, 0);
      ctl(3'b000);
    end
    sweep("R7 programmed array");

    // R6 R8 erase every page
    for (int p = 0; p < DEPTH / 64; p++) begin
      int base = p * 64;
      rd_addr = AW'(base);
      ctl(3'b010);
      wr(base + p % 64, 8'h00);
      wr(base + 1, 8'h00);
      hv_run(3'b110, 1 + p % 3, "R4 erase busy span");
      for (int b = 0; b < 64; b++) model[base + b] = 8'hFF;
      wr(base + 2, 8'h00);
      ctl(3'b000);
      if (p == DEPTH / 128) sweep("R6 R8 half erased");
    end
    sweep("R6 all erased");

    // R8 idle write ignored
    wr(5, 8'h00);
    rd(5, "R8 idle write");

    // R8 write while busy ignored, R7 AND and out-of-row
    ctl(3'b001);
    wr(64, 8'h00);
    hv_delay = 8'd6;
    ctl(3'b101);
    wr(65, 8'h00);
    repeat (6) @(negedge clk);
    chk(!busy, "R4 busy ended", busy, 0);
    rd(65, "R8 busy write");
    wr(66, 8'h0F); model[66] = 8'h0F;
    rd(66, "R7 and first");
    wr(66, 8'hF0); model[66] = 8'h00;
    rd(66, "R7 and second");
    wr(200, 8'h00);
    chk(err, "R7 out of row err", err, 1);
    rd(200, "R7 out of row dropped");
    wr(67, 8'h3C); model[67] = 8'h3C;
    chk(err, "R9 err sticky", err, 1);
    rd(67, "R7 after err");
    ctl(3'b000);
    chk(!err, "R9 err cleared", err, 0);

    // R4 high voltage with nothing armed
    ctl(3'b100);
    chk(err && !busy, "R4 unarmed hv", {err, busy}, 2);
    ctl(3'b000);

    // R2 both mode bits rejected, armed erase kept
    ctl(3'b010);
    wr(70, 8'h00);
    ctl(3'b011);
    chk(err, "R2 both bits err", err, 1);
    rd_addr = AW'(66);
    hv_run(3'b110, 2, "R2 state kept");
    for (int b = 64; b < 128; b++) model[b] = 8'hFF;
    rd(66, "R6 R2 page erased");
    ctl(3'b000);

    // R10 mode change disarms
    ctl(3'b001);
    wr(300, 8'h00);
    ctl(3'b000);
    ctl(3'b101);
    chk(err && !busy, "R10 disarmed", {err, busy}, 2);
    ctl(3'b000);

    // R3 R11 protection boundary 512
    @(negedge clk); prot_we = 1'b1; prot_wdata = 11'd512;
    @(negedge clk); prot_we = 1'b0;
    ctl(3'b010);
    wr(520, 8'h00);
    chk(err, "R3 erase refused", err, 1);
    ctl(3'b110);
    chk(err && !busy, "R3 no arm", {err, busy}, 2);
    ctl(3'b000);
    ctl(3'b001);
    wr(511, 8'h00);
    chk(!err, "R11 below boundary arms", err, 0);
    rd_addr = AW'(511);
    hv_run(3'b101, 1, "R11 program run");
    wr(511, 8'h00); model[511] = 8'h00;
    rd(511, "R11 programmed below boundary");
    ctl(3'b000);
    ctl(3'b001);
    wr(512, 8'h00);
    chk(err, "R3 row at boundary refused", err, 1);
    ctl(3'b000);
    ctl(3'b010);
    wr(500, 8'h00);
    chk(!err, "R3 page below boundary", err, 0);
    hv_run(3'b110, 1, "R6 boundary erase run");
    for (int b = 448; b < 512; b++) model[b] = 8'hFF;
    ctl(3'b000);
    sweep("R3 R6 final array");

    done = 1'b1;
    summary();
  end
endmodule